// File: doc/BRIEF.md
# Prioritised Interrupt Level Resolver

This block watches two request sources: a software request word and a vector of external interrupt lines. Each clock it works out the most urgent pending interrupt level and compares it with the current interrupt priority level. When the pending level is strictly above that level, the block raises a one-cycle trap request. In the same clock edge it latches two values: a summary word showing every pending request bit, and the winning level as an interrupt identifier.

Software requests occupy bits 4 to 18 of the request word. Bit i stands for level i minus 3, so the levels run from 1 to 15. External lines occupy bits 20 to 30 and use their bit index directly as the level. Any pending external line therefore beats every software request. The trap is not repeated while the pending request pattern and the priority level stay the same.

Top module: `int_level_resolver`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the trap output is 0, the summary register is 0 and the identifier register is 0. Reset is synchronous and active high.
- R2: A software request at bit i, with 4 <= i <= 18, resolves to level i-3. Bit 4 gives level 1 and bit 18 gives level 15.
- R3: An external request at bit i, with 20 <= i <= 30, resolves to level i. When any external line in that range is pending, an external level wins over every software request.
- R4: Within one source, the highest pending bit index sets the level.
- R5: The summary is the OR of the pending software bits 4..18 and the pending external bits 20..30, each kept at its own bit position. Software bits 0..3 and 19..31, and external bits 0..19 and 31, are ignored: they add no summary bit and no level.
- R6: A trap is taken only when the resolved level is nonzero and strictly greater than the 5-bit current priority level. When the level is equal or lower, or nothing is pending, the trap output stays 0 and both registers keep their values.
- R7: Inputs are sampled on a rising edge. A trap taken from them appears as a one-cycle pulse after that edge, and the summary and identifier registers take their new values on the same edge. The registers change on no other edge.
- R8: After a trap, no further trap is raised while the summary and the priority level stay unchanged. Once either of them changes and the level still qualifies, a new trap is raised. A cycle with no qualifying level clears this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req_i | input | 32 | Software request word, bits 4..18 used |
| ext_req_i | input | 32 | External interrupt lines, bits 20..30 used |
| cur_ipl_i | input | 5 | Current interrupt priority level |
| trap_o | output | 1 | One-cycle trap request |
| summary_o | output | 32 | Latched summary of pending request bits |
| int_id_o | output | 5 | Latched winning interrupt level |

## Verification
The bench probes the edges of both bit ranges: bits 4 and 18 of the software word, bits 20 and 30 of the external lines, and the neighbouring bits that must be ignored. An off-by-one in the range or the level bias would show up here as a wrong identifier or as a stray summary bit. It sets a pending level equal to the priority level, and then one below it, to catch a comparison that is not strict. It mixes software and external requests to catch an arbiter that lets software win. It holds a request steady across several cycles and then changes first the request and then the priority level. A resolver that re-triggers every cycle, or that never re-arms, produces the wrong number of pulses.

// File: rtl/ilr_pkg.sv
package ilr_pkg;
    localparam int REQ_W  = 32;
    localparam int LVL_W  = 5;
    localparam int SW_LO  = 4;
    localparam int SW_N   = 15;
    localparam int EXT_LO = 20;
    localparam int EXT_N  = 11;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
        logic [REQ_W-1:0] summary;
    } resolve_t;

    function automatic logic [REQ_W-1:0] range_mask(input int lo, input int n);
        logic [REQ_W-1:0] m;
        m = '0;
        for (int i = 0; i < REQ_W; i++)
            if (i >= lo && i < lo + n) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/ilr_scan.sv
module ilr_scan
    import ilr_pkg::*;
#(
    parameter int LO = 4,
    parameter int N  = 15
) (
    input  logic [REQ_W-1:0] vec_i,
    output logic             found_o,
    output logic [LVL_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // ascending walk: a later (higher) set bit overrides an earlier one
        for (int i = LO; i < LO + N; i++) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/ilr_resolve.sv
module ilr_resolve
    import ilr_pkg::*;
#(
    parameter int SWL = SW_LO,
    parameter int SWN = SW_N,
    parameter int EXL = EXT_LO,
    parameter int EXN = EXT_N
) (
    input  logic [REQ_W-1:0] sw_req_i,
    input  logic [REQ_W-1:0] ext_req_i,
    output resolve_t         res_o
);
    localparam logic [REQ_W-1:0] SW_MASK  = range_mask(SWL, SWN);
    localparam logic [REQ_W-1:0] EXT_MASK = range_mask(EXL, EXN);
    localparam logic [LVL_W-1:0] SW_BIAS  = LVL_W'(SWL - 1);

    logic             sw_hit, ext_hit;
    logic [LVL_W-1:0] sw_idx, ext_idx;

    ilr_scan #(.LO(SWL), .N(SWN)) u_sw_scan (
        .vec_i(sw_req_i), .found_o(sw_hit), .idx_o(sw_idx));
    ilr_scan #(.LO(EXL), .N(EXN)) u_ext_scan (
        .vec_i(ext_req_i), .found_o(ext_hit), .idx_o(ext_idx));

    always_comb begin
        res_o.summary = (sw_req_i & SW_MASK) | (ext_req_i & EXT_MASK);
        res_o.valid   = sw_hit | ext_hit;
        if (ext_hit)     res_o.level = ext_idx;
        else if (sw_hit) res_o.level = sw_idx - SW_BIAS;
        else             res_o.level = '0;
    end
endmodule

// File: rtl/ilr_trap_ctl.sv
module ilr_trap_ctl
    import ilr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  resolve_t         res_i,
    input  logic [LVL_W-1:0] cur_ipl_i,
    output logic             trap_o,
    output logic [REQ_W-1:0] summary_o,
    output logic [LVL_W-1:0] int_id_o
);
    logic             held_q;
    logic [REQ_W-1:0] last_sum_q;
    logic [LVL_W-1:0] last_ipl_q;
    logic             take, changed, fire;

    always_comb begin
        take    = res_i.valid && (res_i.level != '0) && (res_i.level > cur_ipl_i);
        changed = (res_i.summary != last_sum_q) || (cur_ipl_i != last_ipl_q);
        fire    = take && (!held_q || changed);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_o     <= 1'b0;
            summary_o  <= '0;
            int_id_o   <= '0;
            held_q     <= 1'b0;
            last_sum_q <= '0;
            last_ipl_q <= '0;
        end else begin
            trap_o <= fire;
            if (fire) begin
                summary_o  <= res_i.summary;
                int_id_o   <= res_i.level;
                held_q     <= 1'b1;
                last_sum_q <= res_i.summary;
                last_ipl_q <= cur_ipl_i;
            end else if (!take) begin
                held_q <= 1'b0;
            end
        end
    end

    AST_TRAP_ABOVE_IPL: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> int_id_o > $past(cur_ipl_i)); // R6
    AST_TRAP_ID_NONZERO: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> int_id_o != '0); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !trap_o && !$past(rst) |-> $stable(summary_o) && $stable(int_id_o)); // R7
    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        trap_o && res_i.summary == summary_o && cur_ipl_i == $past(cur_ipl_i)
        |=> !trap_o); // R8
endmodule

// File: rtl/int_level_resolver.sv
module int_level_resolver
    import ilr_pkg::*;
#(
    parameter int SWL = SW_LO,
    parameter int SWN = SW_N,
    parameter int EXL = EXT_LO,
    parameter int EXN = EXT_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REQ_W-1:0] sw_req_i,
    input  logic [REQ_W-1:0] ext_req_i,
    input  logic [LVL_W-1:0] cur_ipl_i,
    output logic             trap_o,
    output logic [REQ_W-1:0] summary_o,
    output logic [LVL_W-1:0] int_id_o
);
    localparam logic [REQ_W-1:0] SW_MASK  = range_mask(SWL, SWN);
    localparam logic [REQ_W-1:0] EXT_MASK = range_mask(EXL, EXN);

    resolve_t res;

    ilr_resolve #(.SWL(SWL), .SWN(SWN), .EXL(EXL), .EXN(EXN)) u_resolve (
        .sw_req_i(sw_req_i), .ext_req_i(ext_req_i), .res_o(res));

    ilr_trap_ctl u_ctl (
        .clk(clk), .rst(rst), .res_i(res), .cur_ipl_i(cur_ipl_i),
        .trap_o(trap_o), .summary_o(summary_o), .int_id_o(int_id_o));

    AST_EXT_WINS: assert property (@(posedge clk) disable iff (rst)
        trap_o && ($past(ext_req_i & EXT_MASK) != '0) |-> int_id_o >= LVL_W'(EXL)); // R3
    AST_SUMMARY_BITS: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> summary_o == ($past(sw_req_i & SW_MASK) | $past(ext_req_i & EXT_MASK))); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> !trap_o && summary_o == '0 && int_id_o == '0); // R1
endmodule

// File: tb/int_level_resolver_bench.sv
module int_level_resolver_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] sw = '0, ext = '0;
    logic [4:0]  ipl = '0;
    logic        trap;
    logic [31:0] sum;
    logic [4:0]  id;
    int checks = 0, errors = 0;
    logic [31:0] m_sum = '0;
    logic [4:0]  m_id = '0;

    always #5 clk = ~clk;

    int_level_resolver u_int_level_resolver (
        .clk(clk), .rst(rst), .sw_req_i(sw), .ext_req_i(ext), .cur_ipl_i(ipl),
        .trap_o(trap), .summary_o(sum), .int_id_o(id));

    typedef struct packed {
        logic [31:0] sw;
        logic [31:0] ext;
        logic [4:0]  ipl;
        logic        trap;
        logic [4:0]  id;
        logic [31:0] sum;
    } vec_t;

    localparam vec_t TBL [14] = '{
        '{32'h0000_0010, 32'h0, 5'd0,  1'b1, 5'd1,  32'h0000_0010}, // R2 lowest sw
        '{32'h0004_0000, 32'h0, 5'd0,  1'b1, 5'd15, 32'h0004_0000}, // R2 highest sw
        '{32'h0000_0110, 32'h0, 5'd0,  1'b1, 5'd5,  32'h0000_0110}, // R4
        '{32'h0, 32'h0010_0000, 5'd0,  1'b1, 5'd20, 32'h0010_0000}, // R3
        '{32'h0, 32'h4020_0000, 5'd0,  1'b1, 5'd30, 32'h4020_0000}, // R4
        '{32'h0004_0000, 32'h0010_0000, 5'd0, 1'b1, 5'd20, 32'h0014_0000}, // R3
        '{32'h0008_0007, 32'h8008_0000, 5'd0, 1'b0, 5'd0, 32'h0}, // R5 ignored
        '{32'h0000_0017, 32'h0, 5'd0,  1'b1, 5'd1,  32'h0000_0010}, // R5
        '{32'h0, 32'h8010_0000, 5'd0,  1'b1, 5'd20, 32'h0010_0000}, // R5
        '{32'h0000_0100, 32'h0, 5'd5,  1'b0, 5'd0,  32'h0},         // R6 equal
        '{32'h0000_0100, 32'h0, 5'd4,  1'b1, 5'd5,  32'h0000_0100}, // R6
        '{32'h0, 32'h4000_0000, 5'd31, 1'b0, 5'd0,  32'h0},         // R6
        '{32'h0, 32'h4000_0000, 5'd29, 1'b1, 5'd30, 32'h4000_0000}, // R6
        '{32'h0, 32'h0, 5'd0,          1'b0, 5'd0,  32'h0}          // R6 idle
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive at negedge, sample at the following negedge (one register stage)
    task automatic step(input logic [31:0] s, input logic [31:0] e, input logic [4:0] p,
                        input logic exp_trap, input logic [4:0] eid,
                        input logic [31:0] esum, input string req);
        sw = s; ext = e; ipl = p;
        @(negedge clk);
        if (exp_trap) begin m_sum = esum; m_id = eid; end
        chk(req, "trap", 32'(trap), 32'(exp_trap));
        chk(req, "summary", sum, m_sum);
        chk(req, "id", 32'(id), 32'(m_id));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "trap in reset", 32'(trap), 32'd0);
        chk("R1", "summary in reset", sum, 32'd0);
        rst = 1'b0;
        step(32'h0, 32'h0, 5'd0, 1'b0, 5'd0, 32'h0, "R1");

        foreach (TBL[k]) begin
            step(TBL[k].sw, TBL[k].ext, TBL[k].ipl, TBL[k].trap, TBL[k].id,
                 TBL[k].sum, $sformatf("R2..R6 vec%0d", k));
            step(32'h0, 32'h0, 5'd0, 1'b0, 5'd0, 32'h0, "R7 quiet");
        end

        // R7/R8: steady request traps once
        step(32'h10, 32'h0, 5'd0, 1'b1, 5'd1, 32'h10, "R7 first");
        for (int j = 0; j < 4; j++)
            step(32'h10, 32'h0, 5'd0, 1'b0, 5'd0, 32'h0, "R8 steady");
        // new request re-arms
        step(32'h110, 32'h0, 5'd0, 1'b1, 5'd5, 32'h110, "R8 new request");
        step(32'h110, 32'h0, 5'd0, 1'b0, 5'd0, 32'h0, "R8 steady2");
        // priority level change re-arms
        step(32'h110, 32'h0, 5'd2, 1'b1, 5'd5, 32'h110, "R8 ipl change");
        step(32'h110, 32'h0, 5'd10, 1'b0, 5'd0, 32'h0, "R6 masked");
        step(32'h110, 32'h0, 5'd3, 1'b1, 5'd5, 32'h110, "R8 rearm after mask");

        // reset mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "summary after reset", sum, 32'd0);
        chk("R1", "id after reset", 32'(id), 32'd0);
        chk("R1", "trap after reset", 32'(trap), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule